// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a processor load/store port and a 32-bit memory bus. The default geometry holds 8 KB as 512 lines of 16 bytes. Each line carries a valid flag, a lock flag and a tag. A load checks the line selected by the address. When the load hits, the block returns the word without any memory traffic. When it misses, the block fetches the whole line as four word reads, then looks the line up again and answers the load.

Stores are write-through. Every store becomes one memory write. A store that hits also merges its enabled bytes into the cached word. A store that misses does not bring the line in. A separate control port invalidates, locks or unlocks the line selected by an address. A locked line is never replaced. A load that misses on a locked line is fetched as a single uncached word.

Top module: `dcache_dm`

## Requirements
- R1: Address bits [31:13] form the tag, bits [12:4] select one of 512 lines, and bits [3:2] select the word within the line; each line holds 16 bytes.
- R2: A load whose line is valid with an equal tag is a hit. The word is returned with `cpu_ack` high for exactly one cycle, two clock edges after the request is accepted, and no memory read is issued.
- R3: A load miss on an unlocked line issues exactly four reads. Each read has `mem_we`=0 and `mem_be`=4'hF, and the addresses are line base +0, +4, +8 and +12, in that order.
- R4: The acknowledge for a load miss comes only after the fourth refill beat. It returns the requested word. Later loads to any word of that line hit.
- R5: A load miss replaces the indexed line even when it holds a valid line with another tag, and a later load of the old address misses again.
- R6: Every store issues one memory write with the word-aligned address, the store data and the byte enables. `cpu_ack` follows the memory acknowledge.
- R7: A store hit writes the bytes whose enable bit is set (bit n covers data bits [8n+7:8n]) into the cached word. A store miss leaves the cache unchanged, so a later load of that line refills it.
- R8: Control command 2'b00 clears only the valid flag of the addressed line, so the next load to that line refills it.
- R9: Control command 2'b01 locks the addressed line. A load miss that maps onto a locked line issues one uncached read of the requested word and leaves the line unchanged.
- R10: Control command 2'b10 unlocks the addressed line, after which misses replace it again.
- R11: After reset every line is invalid and unlocked, and `cpu_ack`, `ctl_ack` and `mem_req` are low.
- R12: A control request is taken only when no access is in progress, so a request raised during a refill is acknowledged after that load completes. When a control request and a CPU request are both waiting at idle, the control request goes first. Command 2'b11 is acknowledged with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | 32 | Physical byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_ack |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_ack | input | 1 | Memory beat acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| ctl_req | input | 1 | Line maintenance request, held until acknowledged |
| ctl_cmd | input | 2 | 00 invalidate, 01 lock, 10 unlock, 11 no-op |
| ctl_addr | input | 32 | Address selecting the line |
| ctl_ack | output | 1 | One-cycle completion pulse |

## Verification
Two functions can meet in the same cycle: line maintenance from the control port, and a CPU access that is refilling the same line. The bench starts a missing load and raises an invalidate for that line while the refill is under way. It checks that the control acknowledge comes after the load acknowledge. It then checks that the line was invalidated after the fill, so the next load refills it. The bench also raises a control request and a CPU request at the same edge. It judges the order from the cycle in which each acknowledge is seen.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int PADDR_W = 32;
    localparam int WORD_W  = 32;
    localparam int BE_W    = WORD_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOKUP, ST_REFILL, ST_STORE, ST_UNCACHED, ST_DONE, ST_CDONE
    } dc_state_e;

    typedef enum logic [1:0] {
        CMD_FLUSH  = 2'b00,
        CMD_LOCK   = 2'b01,
        CMD_UNLOCK = 2'b10,
        CMD_NONE   = 2'b11
    } dc_cmd_e;

    typedef struct packed {
        logic                we;
        logic [PADDR_W-1:0]  addr;
        logic [WORD_W-1:0]   wdata;
        logic [BE_W-1:0]     be;
    } dc_req_t;

    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [BE_W-1:0]   be
    );
        logic [WORD_W-1:0] res;
        res = old_w;
        for (int b = 0; b < BE_W; b++)
            if (be[b]) res[8*b +: 8] = new_w[8*b +: 8];
        return res;
    endfunction
endpackage

// File: rtl/dc_tag_array.sv
module dc_tag_array
    import dc_pkg::*;
#(
    parameter int NUM_LINES = 512,
    parameter int IDX_W     = 9,
    parameter int TAG_W     = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_lock,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             ctl_we,
    input  logic [IDX_W-1:0] ctl_idx,
    input  dc_cmd_e          ctl_cmd
);
    logic [TAG_W-1:0]     tags [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] lock_q;

    assign rd_tag   = tags[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_lock  = lock_q[rd_idx];

    always_ff @(posedge clk) begin
        if (fill_we) tags[fill_idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            lock_q  <= '0;
        end else begin
            if (fill_we) valid_q[fill_idx] <= 1'b1;
            if (ctl_we) begin
                case (ctl_cmd)
                    CMD_FLUSH:  valid_q[ctl_idx] <= 1'b0;
                    CMD_LOCK:   lock_q[ctl_idx]  <= 1'b1;
                    CMD_UNLOCK: lock_q[ctl_idx]  <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    AST_LOCKED_NOT_FILLED: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> !lock_q[fill_idx]) else $error("locked line refilled"); // R9

    AST_FILL_CTL_APART: assert property (@(posedge clk) disable iff (rst)
        !(fill_we && ctl_we)) else $error("maintenance during refill"); // R12
endmodule

// File: rtl/dc_data_array.sv
module dc_data_array
    import dc_pkg::*;
#(
    parameter int NUM_LINES  = 512,
    parameter int LINE_WORDS = 4,
    parameter int IDX_W      = 9,
    parameter int WSEL_W     = 2
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be
);
    localparam int DEPTH = NUM_LINES * LINE_WORDS;

    logic [WORD_W-1:0] words [DEPTH];

    assign rd_data = words[{rd_idx, rd_word}];

    always_ff @(posedge clk) begin
        if (wr_en)
            words[{wr_idx, wr_word}] <= merge_bytes(words[{wr_idx, wr_word}], wr_data, wr_be);
    end
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
    import dc_pkg::*;
#(
    parameter int IDX_W  = 9,
    parameter int WSEL_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [PADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    input  logic [BE_W-1:0]    cpu_be,
    output logic               cpu_ack,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [PADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic [BE_W-1:0]    mem_be,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               ctl_req,
    input  logic [1:0]         ctl_cmd,
    input  logic [PADDR_W-1:0] ctl_addr,
    output logic               ctl_ack,
    output logic [IDX_W-1:0]   lk_idx,
    input  logic [PADDR_W-IDX_W-WSEL_W-3:0] lk_tag,
    input  logic               lk_valid,
    input  logic               lk_lock,
    output logic               fill_we,
    output logic [PADDR_W-IDX_W-WSEL_W-3:0] fill_tag,
    output logic               tctl_we,
    output logic [IDX_W-1:0]   tctl_idx,
    output dc_cmd_e            tctl_cmd,
    output logic [WSEL_W-1:0]  d_rd_word,
    input  logic [WORD_W-1:0]  d_rd_data,
    output logic               d_wr_en,
    output logic [WSEL_W-1:0]  d_wr_word,
    output logic [WORD_W-1:0]  d_wr_data,
    output logic [BE_W-1:0]    d_wr_be
);
    localparam int OFF_W = WSEL_W + 2;
    localparam int TAG_W = PADDR_W - IDX_W - OFF_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = '1;

    dc_state_e         state_q;
    dc_req_t           req_q;
    logic [WSEL_W-1:0] beat_q;
    logic              hit_q;
    logic              ack_q;
    logic              cack_q;
    logic [WORD_W-1:0] rdata_q;

    logic [TAG_W-1:0]  r_tag;
    logic [IDX_W-1:0]  r_idx;
    logic [WSEL_W-1:0] r_word;
    logic              hit;
    logic              unused_low;

    assign r_tag  = req_q.addr[PADDR_W-1 -: TAG_W];
    assign r_idx  = req_q.addr[OFF_W +: IDX_W];
    assign r_word = req_q.addr[2 +: WSEL_W];
    assign hit    = lk_valid && (lk_tag == r_tag);
    assign unused_low = ^{req_q.addr[1:0], ctl_addr[OFF_W-1:0], ctl_addr[PADDR_W-1 -: TAG_W]};

    assign lk_idx    = r_idx;
    assign d_rd_word = r_word;
    assign fill_tag  = r_tag;
    assign cpu_ack   = ack_q;
    assign cpu_rdata = rdata_q;
    assign ctl_ack   = cack_q;

    assign tctl_we  = (state_q == ST_IDLE) && ctl_req;
    assign tctl_idx = ctl_addr[OFF_W +: IDX_W];
    assign tctl_cmd = dc_cmd_e'(ctl_cmd);

    always_comb begin
        mem_req   = (state_q == ST_REFILL) || (state_q == ST_STORE) || (state_q == ST_UNCACHED);
        mem_we    = (state_q == ST_STORE);
        mem_wdata = req_q.wdata;
        mem_be    = (state_q == ST_STORE) ? req_q.be : '1;
        if (state_q == ST_REFILL) mem_addr = {r_tag, r_idx, beat_q, 2'b00};
        else                      mem_addr = {req_q.addr[PADDR_W-1:2], 2'b00};

        fill_we   = (state_q == ST_REFILL) && mem_ack && (beat_q == LAST_BEAT);
        d_wr_en   = ((state_q == ST_REFILL) && mem_ack) || ((state_q == ST_STORE) && mem_ack && hit_q);
        d_wr_word = (state_q == ST_REFILL) ? beat_q : r_word;
        d_wr_data = (state_q == ST_REFILL) ? mem_rdata : req_q.wdata;
        d_wr_be   = (state_q == ST_REFILL) ? '1 : req_q.be;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            beat_q  <= '0;
            hit_q   <= 1'b0;
            ack_q   <= 1'b0;
            cack_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (ctl_req) begin
                        cack_q  <= 1'b1;
                        state_q <= ST_CDONE;
                    end else if (cpu_req) begin
                        req_q   <= '{we: cpu_we, addr: cpu_addr, wdata: cpu_wdata, be: cpu_be};
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (req_q.we) begin
                        hit_q   <= hit;
                        state_q <= ST_STORE;
                    end else if (hit) begin
                        rdata_q <= d_rd_data;
                        ack_q   <= 1'b1;
                        state_q <= ST_DONE;
                    end else if (lk_lock) begin
                        state_q <= ST_UNCACHED;
                    end else begin
                        beat_q  <= '0;
                        state_q <= ST_REFILL;
                    end
                end
                ST_REFILL: begin
                    if (mem_ack) begin
                        if (beat_q == LAST_BEAT) state_q <= ST_LOOKUP;
                        else                     beat_q  <= beat_q + 1'b1;
                    end
                end
                ST_STORE: begin
                    if (mem_ack) begin
                        ack_q   <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                ST_UNCACHED: begin
                    if (mem_ack) begin
                        rdata_q <= mem_rdata;
                        ack_q   <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    ack_q   <= 1'b0;
                    state_q <= ST_IDLE;
                end
                ST_CDONE: begin
                    cack_q  <= 1'b0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack) else $error("cpu ack longer than one cycle"); // R2

    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOKUP && !req_q.we && hit) |=> !mem_req) else $error("memory used on hit"); // R2

    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REFILL && mem_ack && beat_q != LAST_BEAT) |=>
            (state_q == ST_REFILL && beat_q == WSEL_W'($past(beat_q) + 1'b1))) else $error("beat order"); // R3

    AST_ACKS_APART: assert property (@(posedge clk) disable iff (rst)
        !(cpu_ack && ctl_ack)) else $error("both acks together"); // R12
endmodule

// File: rtl/dcache_dm.sv
module dcache_dm
    import dc_pkg::*;
#(
    parameter int NUM_LINES  = 512,
    parameter int LINE_WORDS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    input  logic [3:0]  cpu_be,
    output logic        cpu_ack,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        ctl_req,
    input  logic [1:0]  ctl_cmd,
    input  logic [31:0] ctl_addr,
    output logic        ctl_ack
);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int TAG_W  = PADDR_W - IDX_W - WSEL_W - 2;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_valid;
    logic              lk_lock;
    logic              fill_we;
    logic [TAG_W-1:0]  fill_tag;
    logic              tctl_we;
    logic [IDX_W-1:0]  tctl_idx;
    dc_cmd_e           tctl_cmd;
    logic [WSEL_W-1:0] d_rd_word;
    logic [WORD_W-1:0] d_rd_data;
    logic              d_wr_en;
    logic [WSEL_W-1:0] d_wr_word;
    logic [WORD_W-1:0] d_wr_data;
    logic [BE_W-1:0]   d_wr_be;

    dc_ctrl #(.IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_ctrl (
        .clk, .rst,
        .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_be, .cpu_ack, .cpu_rdata,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_be, .mem_ack, .mem_rdata,
        .ctl_req, .ctl_cmd, .ctl_addr, .ctl_ack,
        .lk_idx, .lk_tag, .lk_valid, .lk_lock,
        .fill_we, .fill_tag,
        .tctl_we, .tctl_idx, .tctl_cmd,
        .d_rd_word, .d_rd_data,
        .d_wr_en, .d_wr_word, .d_wr_data, .d_wr_be
    );

    dc_tag_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk, .rst,
        .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_valid(lk_valid), .rd_lock(lk_lock),
        .fill_we, .fill_idx(lk_idx), .fill_tag,
        .ctl_we(tctl_we), .ctl_idx(tctl_idx), .ctl_cmd(tctl_cmd)
    );

    dc_data_array #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS),
                    .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
        .clk,
        .rd_idx(lk_idx), .rd_word(d_rd_word), .rd_data(d_rd_data),
        .wr_en(d_wr_en), .wr_idx(lk_idx), .wr_word(d_wr_word),
        .wr_data(d_wr_data), .wr_be(d_wr_be)
    );
endmodule

// File: tb/dcache_dm_test.sv
`timescale 1ns/1ps
module dcache_dm_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        ctl_req = 1'b0;
    logic [1:0]  ctl_cmd = 2'b11;
    logic [31:0] ctl_addr = '0;
    logic        ctl_ack;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 1'b0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] rd_log [64];
    logic [31:0] wr_addr_l, wr_data_l;
    logic [3:0]  wr_be_l;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dcache_dm uut (.*);

    function automatic logic [31:0] mval(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return {w[15:0], w[31:16]} ^ 32'hC3A5_965A;
    endfunction

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r;
        r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: one idle cycle between beats
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    wr_cnt++; wr_addr_l = mem_addr; wr_data_l = mem_wdata; wr_be_l = mem_be;
                end else begin
                    rd_log[rd_cnt % 64] = mem_addr;
                    rd_cnt++;
                    mem_rdata = mval(mem_addr);
                end
            end
        end
    end

    task automatic do_load(input logic [31:0] a, output logic [31:0] d,
                           output int beats, output int lat, output int ackc);
        int r0;
        @(negedge clk);
        r0 = rd_cnt;
        cpu_addr = a; cpu_we = 1'b0; cpu_req = 1'b1; lat = 0;
        do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 300);
        d = cpu_rdata; ackc = cyc; cpu_req = 1'b0;
        beats = rd_cnt - r0;
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        int w0, lat;
        @(negedge clk);
        w0 = wr_cnt;
        cpu_addr = a; cpu_we = 1'b1; cpu_wdata = d; cpu_be = be; cpu_req = 1'b1; lat = 0;
        do begin @(negedge clk); lat++; end while (!cpu_ack && lat < 300);
        cpu_req = 1'b0; cpu_we = 1'b0;
        check(cpu_ack, "R6", "store ack", 32'(cpu_ack), 1);
        check(wr_cnt == w0 + 1, "R6", "store write count", wr_cnt - w0, 1);
        check(wr_addr_l == {a[31:2], 2'b00}, "R6", "store address", wr_addr_l, {a[31:2], 2'b00});
        check(wr_data_l == d && wr_be_l == be, "R6", "store data", wr_data_l, d);
    endtask

    task automatic do_ctl(input logic [1:0] cmd, input logic [31:0] a, output int ackc);
        int lat;
        @(negedge clk);
        ctl_cmd = cmd; ctl_addr = a; ctl_req = 1'b1; lat = 0;
        do begin @(negedge clk); lat++; end while (!ctl_ack && lat < 300);
        ackc = cyc; ctl_req = 1'b0;
        check(ctl_ack, "R12", "control ack", 32'(ctl_ack), 1);
    endtask

    task automatic t_reset();
        check(!cpu_ack && !ctl_ack && !mem_req, "R11", "idle outputs after reset",
              {29'd0, cpu_ack, ctl_ack, mem_req}, 0);
    endtask

    task automatic t_refill();
        logic [31:0] d; int bt, lat, ac, r0;
        r0 = rd_cnt;
        do_load(32'h0000_1234, d, bt, lat, ac);
        check(bt == 4, "R11", "first load misses with 4 beats", bt, 4);
        check(d == mval(32'h1234), "R4", "refill returns requested word", d, mval(32'h1234));
        for (int i = 0; i < 4; i++)
            check(rd_log[(r0 + i) % 64] == 32'h1230 + 4*i, "R3", "refill beat address",
                  rd_log[(r0 + i) % 64], 32'h1230 + 4*i);
        do_load(32'h0000_123C, d, bt, lat, ac);
        check(bt == 0 && d == mval(32'h123C), "R4", "other word of filled line hits", d, mval(32'h123C));
        check(lat == 2, "R2", "hit latency", lat, 2);
        do_load(32'h0000_1238, d, bt, lat, ac);
        check(bt == 0 && d == mval(32'h1238), "R2", "hit data no memory read", d, mval(32'h1238));
    endtask

    task automatic t_conflict();
        logic [31:0] d; int bt, lat, ac;
        do_load(32'h0000_3234, d, bt, lat, ac);
        check(bt == 4 && d == mval(32'h3234), "R5", "same index other tag refills", d, mval(32'h3234));
        do_load(32'h0000_1234, d, bt, lat, ac);
        check(bt == 4, "R1", "tag bits [31:13] distinguish lines", bt, 4);
    endtask

    task automatic t_store();
        logic [31:0] d; int bt, lat, ac;
        do_store(32'h0000_1238, 32'hDEAD_BEEF, 4'b0101);
        do_load(32'h0000_1238, d, bt, lat, ac);
        check(bt == 0 && d == mrg(mval(32'h1238), 32'hDEAD_BEEF, 4'b0101), "R7", "store hit merges bytes",
              d, mrg(mval(32'h1238), 32'hDEAD_BEEF, 4'b0101));
        do_store(32'h0000_5678, 32'h1111_2222, 4'b1111);
        do_load(32'h0000_5678, d, bt, lat, ac);
        check(bt == 4, "R7", "store miss does not allocate", bt, 4);
    endtask

    task automatic t_flush();
        logic [31:0] d; int bt, lat, ac;
        do_ctl(2'b00, 32'h0000_1234, ac);
        do_load(32'h0000_1234, d, bt, lat, ac);
        check(bt == 4 && d == mval(32'h1234), "R8", "flushed line refills", bt, 4);
    endtask

    task automatic t_lock();
        logic [31:0] d; int bt, lat, ac, r0;
        do_ctl(2'b01, 32'h0000_1234, ac);
        r0 = rd_cnt;
        do_load(32'h0000_3238, d, bt, lat, ac);
        check(bt == 1 && rd_log[r0 % 64] == 32'h3238, "R9", "locked miss single uncached read",
              rd_log[r0 % 64], 32'h3238);
        check(d == mval(32'h3238), "R9", "uncached data", d, mval(32'h3238));
        do_load(32'h0000_1230, d, bt, lat, ac);
        check(bt == 0 && d == mval(32'h1230), "R9", "locked line kept", bt, 0);
        do_ctl(2'b10, 32'h0000_1234, ac);
        do_load(32'h0000_3238, d, bt, lat, ac);
        check(bt == 4 && d == mval(32'h3238), "R10", "unlocked line replaced", bt, 4);
    endtask

    task automatic t_overlap();
        logic [31:0] d; int bt, lat, lack, cack;
        fork
            do_load(32'h0000_7004, d, bt, lat, lack);
            begin repeat (4) @(negedge clk); do_ctl(2'b00, 32'h0000_7004, cack); end
        join
        check(bt == 4 && d == mval(32'h7004), "R4", "refill under pending flush", d, mval(32'h7004));
        check(cack > lack, "R12", "flush held until refill done", cack, lack + 1);
        do_load(32'h0000_7008, d, bt, lat, lack);
        check(bt == 4, "R12", "flush applied after refill", bt, 4);
        fork
            do_load(32'h0000_7008, d, bt, lat, lack);
            do_ctl(2'b11, 32'h0000_7008, cack);
        join
        check(cack < lack, "R12", "control first at idle", cack, lack - 1);
        check(bt == 0 && d == mval(32'h7008), "R12", "no-op command has no effect", bt, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_refill();
        t_conflict();
        t_store();
        t_flush();
        t_lock();
        t_overlap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule